// File: doc/BRIEF.md
# Post-Commit Versioned Write Buffer

This block sits beside a private L1 data cache in a core that runs a redundant thread. Every committed store sends the updated cache line here as well as to the L1. The L1 never writes dirty data back: a dirty line it evicts is simply dropped, so this buffer holds the only copy that may reach memory. Entries wait until an external checker declares their epoch good. They then leave for the next memory level, oldest first, through a valid/ready handshake.

Each entry runs a three-state machine: `ENT_INV` (free), `ENT_VAL` (the one searchable version of its line) and `ENT_SUP` (an older version, kept only so that it leaves in order). The transitions are:
- `ALLOC`: `ENT_INV`→`ENT_VAL`
- `MERGE`: `ENT_VAL`→`ENT_VAL`, new data for the same epoch
- `SUPERSEDE`: `ENT_VAL`→`ENT_SUP`, a newer epoch wrote the line
- `DRAIN`: `ENT_VAL`/`ENT_SUP`→`ENT_INV`

Entries are allocated and freed in ring order, so the oldest entry is always at the head. Lookups come from the L1 miss path or from snooped coherence requests. A lookup compares all tags in parallel, and because at most one `ENT_VAL` entry can match, the result needs no priority logic. A search is skipped when the requester reports that the L1 holds the line with its back-pointer set. It is also skipped when a counting Bloom filter shows that the line cannot be present.

Top module: `postcommit_wbuf`

## Requirements
- R1: After reset, `st_ready` is 1 and `wb_valid` and `rsp_valid` are 0.
- R2: A store accepted with no `ENT_VAL` entry for its line allocates the ring tail. Slot indices run 0,1,2,… modulo ENTRIES from reset, and a later lookup reports that slot in `rsp_idx`.
- R3: A store to a line whose `ENT_VAL` entry has the same epoch and is not yet validated overwrites that entry's data in the same slot. No slot is used.
- R4: A store to a line whose `ENT_VAL` entry has another epoch, or is already validated, allocates a new `ENT_VAL` entry and turns the old one into `ENT_SUP`. Lookups then return only the new version, and at most one `ENT_VAL` entry exists per line address.
- R5: `wb_valid` is 1 only when the oldest live entry has been validated. An entry is validated by a `val_valid` pulse whose `val_epoch` equals the entry's epoch, including an entry allocated in the same cycle.
- R6: Write-back leaves in allocation order, `ENT_SUP` entries included, one entry per cycle with `wb_valid && wb_ready`. While stalled, `wb_addr` and `wb_data` hold steady.
- R7: `st_ready` is 0 exactly when all ENTRIES slots are live, and a store offered then is ignored.
- R8: `rsp_valid` follows `lk_valid` by one cycle. `rsp_hit` is 1 when an `ENT_VAL` entry matched `lk_addr` in the request cycle, with its line in `rsp_data` (0 on a miss).
- R9: A lookup with `lk_l1_ptr` = 1 runs no search: `rsp_searched` and `rsp_hit` are 0.
- R10: The filter never hides a present line: a lookup that hits has `rsp_searched` = 1. Each line bumps two of 64 three-bit counters, which stick once they reach 7. If the buffer has never held more than 3 entries since reset and is empty, a lookup is not searched.
- R11: `rsp_set_ptr` is 1 exactly for a hit whose `lk_remote` = 0 (own miss path, L1 refill sets its pointer).
- R12: A written-back entry returns to `ENT_INV` and is no longer found by lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Committed store offers a line |
| st_addr | input | AW | Line address of the store |
| st_data | input | DW | Updated line contents |
| st_epoch | input | EW | Epoch of the store |
| st_ready | output | 1 | A free slot exists |
| val_valid | input | 1 | Epoch validation pulse |
| val_epoch | input | EW | Epoch declared good |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | AW | Line address looked up |
| lk_remote | input | 1 | 1 = snooped coherence request, 0 = own L1 miss |
| lk_l1_ptr | input | 1 | L1 holds the line with its pointer set |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_searched | output | 1 | Tag search was performed |
| rsp_hit | output | 1 | Current version found |
| rsp_data | output | DW | Line contents on a hit |
| rsp_idx | output | $clog2(ENTRIES) | Slot of the hit |
| rsp_set_ptr | output | 1 | Set the L1 pointer bit of the refilled line |
| wb_valid | output | 1 | Validated line ready for memory |
| wb_addr | output | AW | Write-back line address |
| wb_data | output | DW | Write-back line contents |
| wb_ready | input | 1 | Memory accepts the write-back |

## Verification
A corrupted entry state shows at the ports on the next lookup of that line. An entry wrongly left in `ENT_VAL` makes a stale version answer, and an entry wrongly left `ENT_INV` turns a hit into a miss. A stuck head or a lost validation mark shows as `wb_valid` staying low, or as lines leaving out of allocation order, in the cycle the oldest entry should leave. A free count that runs too high or too low shows in `st_ready` the first cycle the ring fills. Filter counters that drop too early show as a missed hit on the next lookup of an affected line, and counters that never return to zero show as a search on an empty buffer.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
    typedef enum logic [1:0] {
        ENT_INV = 2'd0,
        ENT_VAL = 2'd1,
        ENT_SUP = 2'd2
    } ent_state_e;
endpackage

// File: rtl/pcb_entry.sv
module pcb_entry
    import pcb_pkg::*;
#(
    parameter int AW = 26,
    parameter int DW = 64,
    parameter int EW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_i,
    input  logic          merge_i,
    input  logic          sup_i,
    input  logic          drain_i,
    input  logic          val_valid_i,
    input  logic [EW-1:0] val_epoch_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    input  logic [EW-1:0] epoch_i,
    output ent_state_e    state_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o,
    output logic [EW-1:0] epoch_o,
    output logic          ok_o
);
    ent_state_e    state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic [EW-1:0] epoch_q;
    logic          ok_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENT_INV;
        else        state_q <= state_d;
    end

    // transitions: ALLOC, MERGE (stays), SUPERSEDE, DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENT_INV: if (alloc_i) state_d = ENT_VAL;
            ENT_VAL: begin
                if (drain_i)    state_d = ENT_INV;
                else if (sup_i) state_d = ENT_SUP;
            end
            ENT_SUP: if (drain_i) state_d = ENT_INV;
            default: state_d = ENT_INV;
        endcase
    end

    // payload fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            data_q  <= '0;
            epoch_q <= '0;
            ok_q    <= 1'b0;
        end else if (alloc_i) begin
            addr_q  <= addr_i;
            data_q  <= data_i;
            epoch_q <= epoch_i;
            ok_q    <= val_valid_i && (val_epoch_i == epoch_i);
        end else begin
            if (merge_i) data_q <= data_i;
            if (state_q != ENT_INV && val_valid_i && val_epoch_i == epoch_q)
                ok_q <= 1'b1;
        end
    end

    assign state_o = state_q;
    assign addr_o  = addr_q;
    assign data_o  = data_q;
    assign epoch_o = epoch_q;
    assign ok_o    = ok_q;
endmodule

// File: rtl/pcb_bloom.sv
module pcb_bloom #(
    parameter int AW    = 26,
    parameter int SLOTS = 64,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_en,
    input  logic [AW-1:0] inc_addr,
    input  logic          dec_en,
    input  logic [AW-1:0] dec_addr,
    input  logic [AW-1:0] q_addr,
    output logic          q_pass
);
    localparam int HB = $clog2(SLOTS);
    localparam logic [CW-1:0] CMAX = '1;

    function automatic logic [HB-1:0] hash_a(input logic [AW-1:0] a);
        logic [HB-1:0] h;
        h = '0;
        for (int b = 0; b < AW; b++) h[b % HB] = h[b % HB] ^ a[b];
        return h;
    endfunction

    function automatic logic [HB-1:0] hash_b(input logic [AW-1:0] a);
        logic [HB-1:0] h;
        h = '0;
        for (int b = 0; b < AW; b++)
            h[(b + b / HB + 1) % HB] = h[(b + b / HB + 1) % HB] ^ a[b];
        return h;
    endfunction

    logic [CW-1:0] cnt_q [SLOTS];
    logic [HB-1:0] ia, ib, da, db, qa, qb;

    assign ia = hash_a(inc_addr);
    assign ib = hash_b(inc_addr);
    assign da = hash_a(dec_addr);
    assign db = hash_b(dec_addr);
    assign qa = hash_a(q_addr);
    assign qb = hash_b(q_addr);

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [CW+1:0] up, dn, sum, nxt;
        always_comb begin
            up  = {{(CW+1){1'b0}}, inc_en && ia == HB'(s)}
                + {{(CW+1){1'b0}}, inc_en && ib == HB'(s)};
            dn  = {{(CW+1){1'b0}}, dec_en && da == HB'(s)}
                + {{(CW+1){1'b0}}, dec_en && db == HB'(s)};
            sum = {2'b00, cnt_q[s]} + up;
            if (cnt_q[s] == CMAX)          nxt = {2'b00, CMAX};
            else if (sum < dn)             nxt = '0;
            else if (sum - dn > {2'b00, CMAX}) nxt = {2'b00, CMAX};
            else                           nxt = sum - dn;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) cnt_q[s] <= '0;
            else        cnt_q[s] <= nxt[CW-1:0];
        end
    end

    assign q_pass = (cnt_q[qa] != '0) && (cnt_q[qb] != '0);
endmodule

// File: rtl/postcommit_wbuf.sv
module postcommit_wbuf
    import pcb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int AW      = 26,
    parameter int DW      = 64,
    parameter int EW      = 4,
    parameter int FSLOTS  = 64,
    parameter int FCW     = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       st_valid,
    input  logic [AW-1:0]              st_addr,
    input  logic [DW-1:0]              st_data,
    input  logic [EW-1:0]              st_epoch,
    output logic                       st_ready,
    input  logic                       val_valid,
    input  logic [EW-1:0]              val_epoch,
    input  logic                       lk_valid,
    input  logic [AW-1:0]              lk_addr,
    input  logic                       lk_remote,
    input  logic                       lk_l1_ptr,
    output logic                       rsp_valid,
    output logic                       rsp_searched,
    output logic                       rsp_hit,
    output logic [DW-1:0]              rsp_data,
    output logic [$clog2(ENTRIES)-1:0] rsp_idx,
    output logic                       rsp_set_ptr,
    output logic                       wb_valid,
    output logic [AW-1:0]              wb_addr,
    output logic [DW-1:0]              wb_data,
    input  logic                       wb_ready
);
    localparam int IW   = $clog2(ENTRIES);
    localparam int CNTW = IW + 1;
    localparam logic [CNTW-1:0] FULL = CNTW'(ENTRIES);

    ent_state_e    ent_st    [ENTRIES];
    logic [AW-1:0] ent_addr  [ENTRIES];
    logic [DW-1:0] ent_data  [ENTRIES];
    logic [EW-1:0] ent_epoch [ENTRIES];
    logic          ent_ok    [ENTRIES];

    logic [IW-1:0]   head_q, tail_q;
    logic [CNTW-1:0] count_q;
    logic [ENTRIES-1:0] st_vmatch, st_merge, lk_vmatch;
    logic [ENTRIES-1:0] alloc_v, merge_v, sup_v, drain_v;
    logic do_store, merge_any, do_alloc, wb_fire, f_pass, search;

    assign st_ready  = (count_q != FULL);
    assign do_store  = st_valid && st_ready;
    assign merge_any = |st_merge;
    assign do_alloc  = do_store && !merge_any;

    assign wb_valid = (count_q != '0) && (ent_st[head_q] != ENT_INV) && ent_ok[head_q];
    assign wb_addr  = ent_addr[head_q];
    assign wb_data  = ent_data[head_q];
    assign wb_fire  = wb_valid && wb_ready;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        assign st_vmatch[i] = (ent_st[i] == ENT_VAL) && (ent_addr[i] == st_addr);
        assign st_merge[i]  = st_vmatch[i] && (ent_epoch[i] == st_epoch) && !ent_ok[i];
        assign lk_vmatch[i] = (ent_st[i] == ENT_VAL) && (ent_addr[i] == lk_addr);
        assign alloc_v[i]   = do_alloc && (tail_q == IW'(i));
        assign merge_v[i]   = do_store && st_merge[i];
        assign sup_v[i]     = do_alloc && st_vmatch[i];
        assign drain_v[i]   = wb_fire && (head_q == IW'(i));

        pcb_entry #(.AW(AW), .DW(DW), .EW(EW)) u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_i    (alloc_v[i]),
            .merge_i    (merge_v[i]),
            .sup_i      (sup_v[i]),
            .drain_i    (drain_v[i]),
            .val_valid_i(val_valid),
            .val_epoch_i(val_epoch),
            .addr_i     (st_addr),
            .data_i     (st_data),
            .epoch_i    (st_epoch),
            .state_o    (ent_st[i]),
            .addr_o     (ent_addr[i]),
            .data_o     (ent_data[i]),
            .epoch_o    (ent_epoch[i]),
            .ok_o       (ent_ok[i])
        );
    end

    // ring pointers: allocation at tail, write-back at head
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (do_alloc) tail_q <= tail_q + 1'b1;
            if (wb_fire)  head_q <= head_q + 1'b1;
            count_q <= count_q + CNTW'(do_alloc) - CNTW'(wb_fire);
        end
    end

    pcb_bloom #(.AW(AW), .SLOTS(FSLOTS), .CW(FCW)) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_en  (do_alloc),
        .inc_addr(st_addr),
        .dec_en  (wb_fire),
        .dec_addr(wb_addr),
        .q_addr  (lk_addr),
        .q_pass  (f_pass)
    );

    // parallel match: at most one bit of lk_vmatch is set, so OR-merge suffices
    logic          lk_any;
    logic [DW-1:0] lk_data;
    logic [IW-1:0] lk_idx;
    always_comb begin
        lk_any  = |lk_vmatch;
        lk_data = '0;
        lk_idx  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            lk_data = lk_data | (lk_vmatch[i] ? ent_data[i] : '0);
            lk_idx  = lk_idx  | (lk_vmatch[i] ? IW'(i) : '0);
        end
    end

    assign search = lk_valid && !lk_l1_ptr && f_pass;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_searched <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_data     <= '0;
            rsp_idx      <= '0;
            rsp_set_ptr  <= 1'b0;
        end else begin
            rsp_valid    <= lk_valid;
            rsp_searched <= search;
            rsp_hit      <= search && lk_any;
            rsp_data     <= (search && lk_any) ? lk_data : '0;
            rsp_idx      <= (search && lk_any) ? lk_idx : '0;
            rsp_set_ptr  <= search && lk_any && !lk_remote;
        end
    end
endmodule

// File: rtl/postcommit_wbuf_chk.sv
module postcommit_wbuf_chk #(
    parameter int ENTRIES = 8,
    parameter int AW      = 26,
    parameter int DW      = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic               lk_l1_ptr,
    input logic               rsp_valid,
    input logic               rsp_searched,
    input logic               rsp_hit,
    input logic               rsp_set_ptr,
    input logic               wb_valid,
    input logic               wb_ready,
    input logic [AW-1:0]      wb_addr,
    input logic [DW-1:0]      wb_data,
    input logic [ENTRIES-1:0] st_vmatch,
    input logic [ENTRIES-1:0] lk_vmatch
);
    // R4
    one_version_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_vmatch) && $onehot0(lk_vmatch));

    // R6
    wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr) && $stable(wb_data));

    // R9
    ptr_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && lk_l1_ptr |=> rsp_valid && !rsp_searched && !rsp_hit);

    // R8
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    // R8
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    // R10
    hit_searched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_searched && rsp_valid);

    // R11
    set_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_set_ptr |-> rsp_hit);
endmodule

bind postcommit_wbuf postcommit_wbuf_chk #(.ENTRIES(ENTRIES), .AW(AW), .DW(DW)) u_chk (.*);

// File: tb/postcommit_wbuf_test.sv
module postcommit_wbuf_test;
    localparam int N  = 8;
    localparam int AW = 26;
    localparam int DW = 64;
    localparam int EW = 4;
    localparam int IW = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st_valid = 0;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic [EW-1:0] st_epoch = '0;
    logic st_ready;
    logic val_valid = 0;
    logic [EW-1:0] val_epoch = '0;
    logic lk_valid = 0;
    logic [AW-1:0] lk_addr = '0;
    logic lk_remote = 0, lk_l1_ptr = 0;
    logic rsp_valid, rsp_searched, rsp_hit, rsp_set_ptr;
    logic [DW-1:0] rsp_data;
    logic [IW-1:0] rsp_idx;
    logic wb_valid, wb_ready = 0;
    logic [AW-1:0] wb_addr;
    logic [DW-1:0] wb_data;

    always #4 clk = ~clk;

    postcommit_wbuf #(.ENTRIES(N), .AW(AW), .DW(DW), .EW(EW)) uut (.*);

    typedef struct {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [EW-1:0] ep;
        bit ok;
        bit sup;
    } ment_t;

    ment_t q[$];
    int hidx = 0, maxsz = 0;
    int checks = 0, fails = 0;
    bit done = 0;
    logic r_hit; logic [DW-1:0] r_data; logic [IW-1:0] r_idx;

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic cyc();
        bit eready, ewbv, fire, ehit, pre_empty, in_lkv, in_ptr, in_rem;
        logic [DW-1:0] edata;
        int eidx, k;
        ment_t nq[$];
        ment_t ne;
        eready = q.size() < N;
        ewbv = q.size() > 0 && q[0].ok;
        chk(st_ready === eready, "R7 st_ready", 64'(st_ready), 64'(eready));
        chk(wb_valid === ewbv, "R5 wb_valid", 64'(wb_valid), 64'(ewbv));
        if (ewbv && wb_valid) begin
            chk(wb_addr === q[0].addr, "R6 wb_addr order", 64'(wb_addr), 64'(q[0].addr));
            chk(wb_data === q[0].data, "R6 wb_data", wb_data, q[0].data);
        end
        ehit = 0; edata = '0; eidx = 0;
        foreach (q[j]) if (!q[j].sup && q[j].addr == lk_addr) begin
            ehit = 1; edata = q[j].data; eidx = (hidx + j) % N;
        end
        in_lkv = lk_valid; in_ptr = lk_l1_ptr; in_rem = lk_remote;
        pre_empty = (q.size() == 0);
        fire = ewbv && wb_ready;
        nq = q;
        if (st_valid && eready) begin
            k = -1;
            foreach (nq[j]) if (!nq[j].sup && nq[j].addr == st_addr) k = j;
            if (k >= 0 && nq[k].ep == st_epoch && !nq[k].ok) nq[k].data = st_data;
            else begin
                if (k >= 0) nq[k].sup = 1;
                ne.addr = st_addr; ne.data = st_data; ne.ep = st_epoch;
                ne.ok = 0; ne.sup = 0;
                nq.push_back(ne);
            end
        end
        if (val_valid) foreach (nq[j]) if (nq[j].ep == val_epoch) nq[j].ok = 1;
        if (fire) begin
            void'(nq.pop_front());
            hidx = (hidx + 1) % N;
        end
        @(posedge clk);
        q = nq;
        if (q.size() > maxsz) maxsz = q.size();
        #2;
        r_hit = rsp_hit; r_data = rsp_data; r_idx = rsp_idx;
        chk(rsp_valid === in_lkv, "R8 rsp_valid", 64'(rsp_valid), 64'(in_lkv));
        if (in_lkv) begin
            if (in_ptr) begin
                chk(rsp_searched === 1'b0, "R9 pointer skip searched", 64'(rsp_searched), 0);
                chk(rsp_hit === 1'b0, "R9 pointer skip hit", 64'(rsp_hit), 0);
            end else if (ehit) begin
                chk(rsp_searched === 1'b1, "R10 filter passes present line", 64'(rsp_searched), 1);
                chk(rsp_hit === 1'b1, "R8 hit", 64'(rsp_hit), 1);
                chk(rsp_data === edata, "R8 data", rsp_data, edata);
                chk(rsp_idx === IW'(eidx), "R2 slot index", 64'(rsp_idx), 64'(eidx));
                chk(rsp_set_ptr === !in_rem, "R11 set_ptr", 64'(rsp_set_ptr), 64'(!in_rem));
            end else begin
                chk(rsp_hit === 1'b0, "R8 miss", 64'(rsp_hit), 0);
                chk(rsp_data === '0, "R8 miss data", rsp_data, 0);
                chk(rsp_set_ptr === 1'b0, "R11 no set_ptr on miss", 64'(rsp_set_ptr), 0);
                if (pre_empty && maxsz <= 3)
                    chk(rsp_searched === 1'b0, "R10 empty filter skips", 64'(rsp_searched), 0);
            end
        end
    endtask

    task automatic idle();
        st_valid = 0; val_valid = 0; lk_valid = 0; lk_l1_ptr = 0; lk_remote = 0;
    endtask

    task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [EW-1:0] e);
        idle(); st_valid = 1; st_addr = a; st_data = d; st_epoch = e;
        cyc(); idle();
    endtask

    task automatic lookup(input logic [AW-1:0] a, input bit rem, input bit ptr);
        idle(); lk_valid = 1; lk_addr = a; lk_remote = rem; lk_l1_ptr = ptr;
        cyc(); idle();
    endtask

    task automatic validate(input logic [EW-1:0] e);
        idle(); val_valid = 1; val_epoch = e;
        cyc(); idle();
    endtask

    localparam logic [AW-1:0] LA = 26'h0012345;
    localparam logic [AW-1:0] LB = 26'h0abcd01;

    initial begin
        logic [EW-1:0] cur, vnext;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        // R1 reset state
        chk(st_ready === 1'b1, "R1 st_ready after reset", 64'(st_ready), 1);
        chk(wb_valid === 1'b0, "R1 wb_valid after reset", 64'(wb_valid), 0);
        chk(rsp_valid === 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid), 0);

        lookup(LA, 0, 0);
        store(LA, 64'h1, 0);
        store(LB, 64'h2, 0);
        store(LA, 64'h3, 0);
        lookup(LA, 0, 0);
        chk(r_hit && r_idx == 0 && r_data == 64'h3, "R3 merge in place", 64'(r_idx), 0);
        lookup(LB, 1, 0);
        lookup(LA, 1, 1);
        store(LA, 64'h4, 1);
        lookup(LA, 0, 0);
        chk(r_hit && r_idx == 2 && r_data == 64'h4, "R4 newer version", 64'(r_idx), 2);
        wb_ready = 1;
        cyc(); cyc();
        chk(wb_valid === 1'b0, "R5 no drain before validation", 64'(wb_valid), 0);
        wb_ready = 0;
        validate(0);
        cyc(); cyc();
        wb_ready = 1;
        cyc(); cyc(); cyc();
        lookup(LB, 0, 0);
        chk(r_hit === 1'b0, "R12 drained line gone", 64'(r_hit), 0);
        for (int i = 0; i < 7; i++) store(26'h100 + 26'(i * 97), 64'(i + 16), 1);
        store(26'h3fff00, 64'hdead, 1);
        lookup(26'h3fff00, 0, 0);
        chk(r_hit === 1'b0, "R7 store while full ignored", 64'(r_hit), 0);
        validate(1);
        repeat (10) cyc();
        chk(q.size() == 0 && wb_valid === 1'b0, "R12 all drained", 64'(wb_valid), 0);

        cur = 2; vnext = 2;
        for (int c = 0; c < 4000; c++) begin
            idle();
            st_valid = ($urandom % 2) == 0;
            st_addr = 26'h40 + 26'(($urandom % 6) * 1237);
            st_data = {$urandom, $urandom};
            st_epoch = cur;
            lk_valid = ($urandom % 3) != 0;
            lk_addr = 26'h40 + 26'(($urandom % 7) * 1237);
            lk_remote = $urandom % 2;
            lk_l1_ptr = ($urandom % 6) == 0;
            wb_ready = ($urandom % 10) < 7;
            if (vnext != cur && ($urandom % 8) == 0) begin
                val_valid = 1; val_epoch = vnext; vnext = vnext + 1'b1;
            end
            cyc();
            if (4'(cur - vnext) < 3 && ($urandom % 10) == 0) cur = cur + 1'b1;
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule